// File: doc/BRIEF.md
# Two-Socket Memory Chip-Select Decoder

This block turns a 16-bit processor memory address into active-low chip selects for two byte-wide memory sockets in the lowest 16K of the address space. Socket A holds an EPROM of 4K, 8K or 16K. Socket B holds a 4K or 8K EPROM, or a 2K or 8K static RAM. Two configuration codes, normally tied off by straps, tell the decoder which part sits in each socket.

When socket A holds a 16K part, its window takes over socket B's range and socket B is never selected, so the two parts cannot fight over the bus. Besides the selects, the block drives a per-socket read enable and a socket B write enable. It masks the address passed to the parts so that smaller parts repeat within their window. It also raises a wait request on every access to the lowest 16K.

The wait request can be turned off with a strap. When it is on, the wait lasts a fixed number of clock cycles from the start of each memory request. An unused configuration code raises an error flag and blocks both selects. All outputs except the wait come straight from the current inputs. The wait also depends on how many cycles the current request has been held.

Top module: `memdec_top`

## Requirements
- R1: With `a_code` = 2'b10 (16K part), `cs_a_n` is low for every requested address from 0000h to 3FFFh.
- R2: With `a_code` = 2'b00 (4K) or 2'b01 (8K), `cs_a_n` is low only for requested addresses 0000h to 1FFFh.
- R3: Unless `a_code` is 2'b10 or 2'b11, `cs_b_n` is low for every requested address from 2000h to 3FFFh. This holds for every `b_code`: 2'b00 4K EPROM, 2'b01 8K EPROM, 2'b10 2K RAM, 2'b11 8K RAM.
- R4: With `a_code` = 2'b10, `cs_b_n` stays high, and the two selects are never low together.
- R5: For addresses 4000h and above, both selects and `wait_n` stay high.
- R6: While `mem_req` is low, both selects, all enables and `wait_n` stay high, and `mem_addr` is zero.
- R7: `oe_a_n` and `oe_b_n` are low exactly when their socket is selected and `rd` is high. `we_b_n` is low only when socket B is selected, `wr` is high and `b_code[1]` is 1 (a RAM).
- R8: `mem_addr` carries the address masked to the selected part: 12 bits for 4K, 13 for 8K, 14 for 16K, 11 for 2K. The upper bits read zero, so smaller parts repeat across their window. It is zero when no socket is selected.
- R9: With `wait_en` high, `wait_n` is low during the first WAIT_CYCLES cycles of a request whose address is below 4000h. It then goes high for the rest of that request, and a new count starts only after `mem_req` has dropped. The configuration codes do not affect this.
- R10: With `wait_en` low, `wait_n` stays high.
- R11: With `a_code` = 2'b11, `cfg_err` is high and both selects and all enables stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the wait counter |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor memory address |
| mem_req | input | 1 | Memory request, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| a_code | input | 2 | Socket A part code |
| b_code | input | 2 | Socket B part code |
| wait_en | input | 1 | Strap that lets the wait reach the processor |
| cs_a_n | output | 1 | Socket A chip select, active low |
| cs_b_n | output | 1 | Socket B chip select, active low |
| oe_a_n | output | 1 | Socket A output enable, active low |
| oe_b_n | output | 1 | Socket B output enable, active low |
| we_b_n | output | 1 | Socket B write enable, active low |
| mem_addr | output | 14 | Part-local address, masked to part size |
| wait_n | output | 1 | Wait request to processor, active low |
| cfg_err | output | 1 | Unused configuration code flag |

## Verification
The bench builds the decoder with WAIT_CYCLES set to 3 rather than the default 1. This lets a multi-cycle wait hold, release partway through a long request, and rearm after a gap. The address width stays at 16, so the window edges at 1FFFh/2000h and 3FFFh/4000h are reached directly. Part sizes are swept over every code pair, and the aliased addresses are compared at the edges of each part.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

  typedef enum logic [1:0] {
    A_4K  = 2'b00,
    A_8K  = 2'b01,
    A_16K = 2'b10,
    A_BAD = 2'b11
  } a_part_e;

  typedef enum logic [1:0] {
    B_ROM4K = 2'b00,
    B_ROM8K = 2'b01,
    B_RAM2K = 2'b10,
    B_RAM8K = 2'b11
  } b_part_e;

  typedef struct packed {
    logic       err;
    logic [4:0] a_win_lg;
    logic [4:0] a_part_lg;
    logic       b_en;
    logic       b_ram;
    logic [4:0] b_part_lg;
  } dec_cfg_t;

endpackage

// File: rtl/memdec_cfg.sv
module memdec_cfg
  import memdec_pkg::*;
#(
  parameter int LOW_W = 14
) (
  input  logic [1:0] a_code,
  input  logic [1:0] b_code,
  output dec_cfg_t   cfg
);
  localparam logic [4:0] HALF_LG = 5'(LOW_W - 1);
  localparam logic [4:0] FULL_LG = 5'(LOW_W);

  always_comb begin
    cfg = '0;
    cfg.b_en = 1'b1;
    unique case (a_part_e'(a_code))
      A_4K:  begin cfg.a_win_lg = HALF_LG; cfg.a_part_lg = 5'd12; end
      A_8K:  begin cfg.a_win_lg = HALF_LG; cfg.a_part_lg = 5'd13; end
      A_16K: begin cfg.a_win_lg = FULL_LG; cfg.a_part_lg = 5'd14; cfg.b_en = 1'b0; end
      default: begin
        cfg.err       = 1'b1;
        cfg.a_win_lg  = HALF_LG;
        cfg.a_part_lg = 5'd12;
        cfg.b_en      = 1'b0;
      end
    endcase
    unique case (b_part_e'(b_code))
      B_ROM4K: cfg.b_part_lg = 5'd12;
      B_ROM8K: cfg.b_part_lg = 5'd13;
      B_RAM2K: begin cfg.b_part_lg = 5'd11; cfg.b_ram = 1'b1; end
      default: begin cfg.b_part_lg = 5'd13; cfg.b_ram = 1'b1; end
    endcase
  end
endmodule

// File: rtl/memdec_window.sv
module memdec_window #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              req,
  input  logic              en,
  input  logic [4:0]        win_lg,
  input  logic [4:0]        part_lg,
  output logic              sel,
  output logic [ADDR_W-1:0] local_addr
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] part_mask;

  always_comb begin
    win_mask   = {ADDR_W{1'b1}} << win_lg;
    part_mask  = ~({ADDR_W{1'b1}} << part_lg);
    sel        = req && en && ((addr & win_mask) == BASE_V);
    local_addr = addr & part_mask;
  end
endmodule

// File: rtl/memdec_wait.sv
module memdec_wait #(
  parameter int WAIT_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic hit,
  input  logic strap,
  output logic wait_n
);
  localparam int CW = $clog2(WAIT_CYCLES + 2);

  generate
    if (WAIT_CYCLES == 0) begin : g_nowait
      assign wait_n = 1'b1;
    end else begin : g_count
      localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYCLES);
      logic [CW-1:0] held;

      always_ff @(posedge clk) begin
        if (!rst_n)             held <= '0;
        else if (!req)          held <= '0;
        else if (held != LIMIT) held <= held + 1'b1;
      end

      assign wait_n = !(req && hit && strap && (held < LIMIT));

      // R9
      wait_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req) |=> (held == '0));
    end
  endgenerate

  // R9
  wait_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n) |-> (req && hit));
  // R10
  wait_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap) |-> wait_n);
endmodule

// File: rtl/memdec_top.sv
module memdec_top
  import memdec_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LOW_W       = 14,
  parameter int WAIT_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_req,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        a_code,
  input  logic [1:0]        b_code,
  input  logic              wait_en,
  output logic              cs_a_n,
  output logic              cs_b_n,
  output logic              oe_a_n,
  output logic              oe_b_n,
  output logic              we_b_n,
  output logic [LOW_W-1:0]  mem_addr,
  output logic              wait_n,
  output logic              cfg_err
);
  localparam int         B_BASE = 1 << (LOW_W - 1);
  localparam logic [4:0] B_WIN  = 5'(LOW_W - 1);

  dec_cfg_t          cfg;
  logic              sel_a, sel_b, cs_a, cs_b, in_low;
  logic [ADDR_W-1:0] loc_a, loc_b;

  memdec_cfg #(.LOW_W(LOW_W)) u_cfg (.a_code(a_code), .b_code(b_code), .cfg(cfg));

  memdec_window #(.ADDR_W(ADDR_W), .BASE(0)) u_win_a (
    .addr(addr), .req(mem_req), .en(1'b1), .win_lg(cfg.a_win_lg),
    .part_lg(cfg.a_part_lg), .sel(sel_a), .local_addr(loc_a));

  memdec_window #(.ADDR_W(ADDR_W), .BASE(B_BASE)) u_win_b (
    .addr(addr), .req(mem_req), .en(cfg.b_en), .win_lg(B_WIN),
    .part_lg(cfg.b_part_lg), .sel(sel_b), .local_addr(loc_b));

  assign in_low = (addr[ADDR_W-1:LOW_W] == '0);

  memdec_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst_n(rst_n), .req(mem_req), .hit(in_low),
    .strap(wait_en), .wait_n(wait_n));

  always_comb begin
    cs_a    = sel_a && !cfg.err;
    cs_b    = sel_b && !cfg.err;
    cs_a_n  = !cs_a;
    cs_b_n  = !cs_b;
    oe_a_n  = !(cs_a && rd);
    oe_b_n  = !(cs_b && rd);
    we_b_n  = !(cs_b && wr && cfg.b_ram);
    cfg_err = cfg.err;
    if (cs_a)      mem_addr = loc_a[LOW_W-1:0];
    else if (cs_b) mem_addr = loc_b[LOW_W-1:0];
    else           mem_addr = '0;
  end

  // R4
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_a_n && !cs_b_n));
  // R4
  b_off_a16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_code == 2'b10) |-> cs_b_n);
  // R5
  high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:LOW_W] != '0) |-> (cs_a_n && cs_b_n && wait_n));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req) |-> (cs_a_n && cs_b_n && oe_a_n && oe_b_n && we_b_n && wait_n));
  // R7
  rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_code[1]) |-> we_b_n);
  // R11
  bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_code == 2'b11) |-> (cfg_err && cs_a_n && cs_b_n && we_b_n));
endmodule

// File: tb/tb_memdec_top.sv
module tb_memdec_top;
  localparam int WC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mem_req = 1'b0, rd = 1'b0, wr = 1'b0, wait_en = 1'b0;
  logic [1:0]  a_code = '0, b_code = '0;
  logic        cs_a_n, cs_b_n, oe_a_n, oe_b_n, we_b_n, wait_n, cfg_err;
  logic [13:0] mem_addr;

  int errors = 0, checks = 0, mcnt = 0;

  always #2 clk = ~clk;

  memdec_top #(.ADDR_W(16), .LOW_W(14), .WAIT_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .rd(rd), .wr(wr),
    .a_code(a_code), .b_code(b_code), .wait_en(wait_en),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .we_b_n(we_b_n), .mem_addr(mem_addr), .wait_n(wait_n), .cfg_err(cfg_err));

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (addr=%h a=%0d b=%0d req=%0b)",
               tag, nm, act, exp, addr, a_code, b_code, mem_req);
    end
  endtask

  task automatic compare(input string tag);
    bit err, a16, csa, csb;
    int ma, mb, ea;
    err = (a_code == 2'd3);
    a16 = (a_code == 2'd2);
    csa = mem_req && !err && (a16 ? addr < 16'h4000 : addr < 16'h2000);
    csb = mem_req && !err && !a16 && addr >= 16'h2000 && addr < 16'h4000;
    ma  = (a_code == 2'd0) ? 'hFFF : (a_code == 2'd1) ? 'h1FFF : 'h3FFF;
    mb  = (b_code == 2'd0) ? 'hFFF : (b_code == 2'd2) ? 'h7FF : 'h1FFF;
    ea  = csa ? (int'(addr) & ma) : csb ? (int'(addr) & mb) : 0;
    chk(tag, "cs_a_n", cs_a_n, !csa);
    chk(tag, "cs_b_n", cs_b_n, !csb);
    chk(tag, "oe_a_n", oe_a_n, !(csa && rd));
    chk(tag, "oe_b_n", oe_b_n, !(csb && rd));
    chk(tag, "we_b_n", we_b_n, !(csb && wr && b_code[1]));
    chk(tag, "mem_addr", mem_addr, ea);
    chk(tag, "cfg_err", cfg_err, err);
    chk(tag, "wait_n", wait_n,
        !(mem_req && addr < 16'h4000 && wait_en && mcnt < WC));
  endtask

  task automatic apply(input logic [15:0] a, input logic r, input logic rdi,
                       input logic wri, input logic [1:0] ac, input logic [1:0] bc,
                       input logic s, input string tag);
    @(negedge clk);
    addr = a; mem_req = r; rd = rdi; wr = wri; a_code = ac; b_code = bc; wait_en = s;
    #1 compare(tag);
    @(posedge clk);
    mcnt = r ? ((mcnt < WC) ? mcnt + 1 : WC) : 0;
  endtask

  logic [15:0] al [12] = '{16'h0000, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'h27FF,
                           16'h2800, 16'h2FFF, 16'h3000, 16'h3FFF, 16'h4000, 16'hFFFF};

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare("R6");
    @(negedge clk) rst_n = 1'b1;
    // R1 / R2: socket A windows per part size
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 12; i++)
        apply(al[i], 1'b1, 1'b1, 1'b0, 2'(c), 2'd1, 1'b0, (c == 2) ? "R1" : "R2");
    // R3 / R4 / R7 / R8: socket B across types, reads and writes
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < 4; b++)
        for (int i = 0; i < 12; i++) begin
          apply(al[i], 1'b1, 1'b0, 1'b1, 2'(c), 2'(b), 1'b0, (c == 2) ? "R4" : "R7");
          apply(al[i] ^ 16'h0123, 1'b1, 1'b1, 1'b0, 2'(c), 2'(b), 1'b0, "R8");
        end
    for (int b = 0; b < 4; b++) apply(16'h3ABC, 1'b1, 1'b1, 1'b0, 2'd0, 2'(b), 1'b0, "R3");
    // R5: high addresses with wait strap on
    apply(16'h4000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 1'b1, "R5");
    for (int i = 0; i < 6; i++) apply(16'h4000 + 16'(i * 16'h1F00), 1'b1, 1'b1, 1'b1, 2'd2, 2'd3, 1'b1, "R5");
    // R6: no request
    for (int i = 0; i < 12; i++) apply(al[i], 1'b0, 1'b1, 1'b1, 2'd0, 2'd3, 1'b1, "R6");
    // R9: wait holds WC cycles, releases, rearms after gap
    for (int i = 0; i < 6; i++) apply(16'h0100, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1, "R9");
    apply(16'h0100, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, "R9");
    for (int i = 0; i < 5; i++) apply(16'h3000, 1'b1, 1'b0, 1'b1, 2'd3, 2'd2, 1'b1, "R9");
    apply(16'h3000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, "R9");
    apply(16'h3000, 1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 1'b1, "R9");
    apply(16'h3000, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1, "R9");
    apply(16'h8000, 1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 1'b1, "R9");
    apply(16'h0000, 1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 1'b1, "R9");
    // R10: strap off
    apply(16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, "R10");
    for (int i = 0; i < 4; i++) apply(16'h0200, 1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, "R10");
    // R11: illegal socket A code
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 12; i++) apply(al[i], 1'b1, 1'b1, 1'b1, 2'd3, 2'(b), 1'b0, "R11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule